// File: doc/BRIEF.md
# CAN Mode Handshake Controller

This block connects the software's mode request bits to the operating state of a CAN controller. Software raises an initialization request or a sleep request. The block answers with acknowledge flags that software reads to confirm each transition. A third output tells the rest of the controller when it is synchronized to the bus and free to take part in traffic.

The block leaves initialization, and also wakes from sleep or comes out of reset, in two steps. After the request is withdrawn, it watches the sampled receive line on each bit-time strobe. It declares synchronization only after it has counted a run of consecutive recessive bits. During that wait after initialization, the initialization acknowledge stays set.

Wake-up is modelled by a single pulse input. It cancels a pending sleep request until software lowers its sleep request bit and raises it again.

Top module: `can_mode_hs`

## Requirements
- R1: On reset, `inak_o`, `slak_o` and `synced_o` are 0. With no request pending, `synced_o` rises only after RUN_LEN (default 11) consecutive recessive strobed samples.
- R2: A cycle with `init_req_i` high makes `inak_o` 1 and `synced_o` 0 from the next cycle.
- R3: When `init_req_i` and `sleep_req_i` are both high, initialization wins and `slak_o` is 0 on the next cycle.
- R4: After `init_req_i` falls, `inak_o` stays 1 until the strobed sample that completes a run of RUN_LEN recessive bits. On the next cycle `inak_o` is 0 and `synced_o` is 1.
- R5: A strobed dominant sample (`rx_i` = 0) during the wait restarts the run from zero.
- R6: The run counts only in cycles where `bit_stb_i` is 1. The value of `rx_i` in cycles without a strobe has no effect.
- R7: An effective sleep request with `init_req_i` low makes `slak_o` 1 and `synced_o` 0 on the next cycle. The two acknowledge flags are never both 1.
- R8: When the effective sleep request goes away, `slak_o` is 0 on the next cycle. `synced_o` then rises only after a full recessive run.
- R9: A `wake_i` pulse while `sleep_req_i` is high cancels the effective sleep request from that cycle onward. The cancellation lasts until `sleep_req_i` is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req_i | input | 1 | Software initialization request (level) |
| sleep_req_i | input | 1 | Software sleep request (level) |
| wake_i | input | 1 | Wake event pulse; cancels the sleep request |
| bit_stb_i | input | 1 | One-cycle strobe at each bit sample point |
| rx_i | input | 1 | Sampled receive line, 1 = recessive |
| inak_o | output | 1 | Initialization acknowledge (read-only status) |
| slak_o | output | 1 | Sleep acknowledge (read-only status) |
| synced_o | output | 1 | Synchronized to bus, normal operation |

## Verification
The assertions assume that all inputs are stable between clock edges and that `bit_stb_i` is a plain per-cycle qualifier. No ordering between the requests is assumed, so the checks must hold under any mix of requests. The random phase changes the request levels only rarely, so that long recessive runs actually complete. It strobes at random intervals and drives the receive line mostly recessive, with occasional dominant samples, so that both completed runs and restarted runs occur. Directed sequences cover the run that falls one bit short, a dominant sample in the middle of a run, dominant values in cycles without a strobe, and the wake cancellation.

// File: rtl/can_mh_pkg.sv
// Package: shared state encoding for the CAN mode handshake controller.
package can_mh_pkg;
    typedef enum logic [2:0] {
        MH_WAIT   = 3'd0,  // resynchronising after reset or sleep, flags low
        MH_INIT   = 3'd1,  // initialization held by request
        MH_SYNC_I = 3'd2,  // request gone, acknowledge still held, counting
        MH_SLEEP  = 3'd3,  // sleep acknowledged
        MH_NORMAL = 3'd4   // synchronized, normal operation
    } mh_state_e;
endpackage

// File: rtl/mh_sleep_gate.sv
// Module: mh_sleep_gate
// Turns the software sleep level into an effective request. A wake pulse
// cancels it until software lowers the sleep bit.
// Assumes: wake_i is sampled on the clock, any width.
module mh_sleep_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_i,
    input  logic wake_i,
    output logic sleep_eff_o
);
    logic wake_blk_q;

    // Purpose: remember a wake event for as long as the sleep bit stays high.
    always_ff @(posedge clk) begin
        if (!rst_n)            wake_blk_q <= 1'b0;
        else if (!sleep_req_i) wake_blk_q <= 1'b0;
        else if (wake_i)       wake_blk_q <= 1'b1;
    end

    // Purpose: the cancellation applies in the cycle of the pulse itself.
    always_comb sleep_eff_o = sleep_req_i && !(wake_blk_q || wake_i);

    AST_WAKE_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_i && sleep_req_i) |=> (!sleep_req_i || !sleep_eff_o)); // R9
endmodule

// File: rtl/mh_run_counter.sv
// Module: mh_run_counter
// Counts consecutive recessive strobed samples and flags the sample that
// completes a run of RUN_LEN.
// Assumes: clear_i is held while the owner is not waiting for sync.
module mh_run_counter #(
    parameter int RUN_LEN = 11,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic bit_stb_i,
    input  logic rx_i,
    output logic done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    // Purpose: advance only in counting cycles that carry a strobe.
    always_comb begin
        adv    = !clear_i && bit_stb_i;
        done_o = adv && rx_i && (cnt_q == LAST);
    end

    // Purpose: run length register; dominant restarts, completion wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)  cnt_q <= '0;
        else if (adv) begin
            if (!rx_i)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(RUN_LEN)); // R4
    AST_DOMINANT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rx_i) |=> (cnt_q == '0)); // R5
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb_i && !clear_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/mh_mode_fsm.sv
// Module: mh_mode_fsm
// Mode state machine: initialization overrides sleep, sleep overrides the
// rest; both exits pass through a recessive-run wait.
// Assumes: run_done_i is only meaningful while counting_o is high.
module mh_mode_fsm
    import can_mh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_req_i,
    input  logic sleep_eff_i,
    input  logic run_done_i,
    output logic counting_o,
    output logic inak_o,
    output logic slak_o,
    output logic synced_o
);
    mh_state_e st_q, st_d;

    // Purpose: next-state selection with request priority.
    always_comb begin
        st_d = st_q;
        if (init_req_i)       st_d = MH_INIT;
        else if (sleep_eff_i) st_d = MH_SLEEP;
        else begin
            unique case (st_q)
                MH_INIT:           st_d = MH_SYNC_I;
                MH_SLEEP:          st_d = MH_WAIT;
                MH_SYNC_I, MH_WAIT: st_d = run_done_i ? MH_NORMAL : st_q;
                default:           st_d = st_q;
            endcase
        end
    end

    // Purpose: state register, reset into the resync wait.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MH_WAIT;
        else        st_q <= st_d;
    end

    // Purpose: decode status flags from state.
    always_comb begin
        counting_o = (st_q == MH_SYNC_I) || (st_q == MH_WAIT);
        inak_o     = (st_q == MH_INIT) || (st_q == MH_SYNC_I);
        slak_o     = (st_q == MH_SLEEP);
        synced_o   = (st_q == MH_NORMAL);
    end
endmodule

// File: rtl/can_mode_hs.sv
// Module: can_mode_hs (top)
// Handshake between software mode requests and controller state; declares
// bus sync after RUN_LEN recessive strobed bits.
// Assumes: bit_stb_i comes from the bit timing logic, rx_i is pre-sampled.
module can_mode_hs #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_req_i,
    input  logic sleep_req_i,
    input  logic wake_i,
    input  logic bit_stb_i,
    input  logic rx_i,
    output logic inak_o,
    output logic slak_o,
    output logic synced_o
);
    logic sleep_eff;
    logic counting;
    logic run_done;

    mh_sleep_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_i (sleep_req_i),
        .wake_i      (wake_i),
        .sleep_eff_o (sleep_eff)
    );

    mh_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (!counting),
        .bit_stb_i (bit_stb_i),
        .rx_i      (rx_i),
        .done_o    (run_done)
    );

    mh_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_req_i  (init_req_i),
        .sleep_eff_i (sleep_eff),
        .run_done_i  (run_done),
        .counting_o  (counting),
        .inak_o      (inak_o),
        .slak_o      (slak_o),
        .synced_o    (synced_o)
    );

    AST_INIT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        init_req_i |=> (inak_o && !synced_o)); // R2
    AST_INIT_OVER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req_i && sleep_req_i) |=> !slak_o); // R3
    AST_INAK_FALL_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inak_o) |-> (synced_o || slak_o)); // R4
    AST_SYNC_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced_o) |-> $past(bit_stb_i && rx_i)); // R6
    AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_eff && !init_req_i) |=> (slak_o && !synced_o)); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(inak_o && slak_o)); // R7
    AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (slak_o && !sleep_eff && !init_req_i) |=> (!slak_o && !synced_o)); // R8
endmodule

// File: tb/sim_can_mode_hs.sv
module sim_can_mode_hs;
    localparam int RUN = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_req = 1'b0, sleep_req = 1'b0, wake = 1'b0, stb = 1'b0, rx = 1'b1;
    logic inak, slak, synced;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    can_mode_hs #(.RUN_LEN(RUN)) u0 (
        .clk(clk), .rst_n(rst_n), .init_req_i(init_req), .sleep_req_i(sleep_req),
        .wake_i(wake), .bit_stb_i(stb), .rx_i(rx),
        .inak_o(inak), .slak_o(slak), .synced_o(synced)
    );

    // Reference model built from the requirements. Modes: 0 wait, 1 init,
    // 2 init-exit wait, 3 sleep, 4 normal.
    int m_st = 0, m_cnt = 0;
    bit m_wb = 1'b0;

    function automatic bit exp_inak(int s);   return s == 1 || s == 2; endfunction
    function automatic bit exp_slak(int s);   return s == 3;           endfunction
    function automatic bit exp_synced(int s); return s == 4;           endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_wb = 1'b0;
        end else begin
            bit se, cnting, dn;
            se     = sleep_req && !(m_wb || wake);
            cnting = (m_st == 0 || m_st == 2);
            dn     = cnting && stb && rx && (m_cnt == RUN - 1);
            if (!cnting) m_cnt = 0;
            else if (stb) m_cnt = (!rx || m_cnt == RUN - 1) ? 0 : m_cnt + 1;
            if (init_req)     m_st = 1;
            else if (se)      m_st = 3;
            else if (m_st == 1) m_st = 2;
            else if (m_st == 3) m_st = 0;
            else if (cnting && dn) m_st = 4;
            m_wb = sleep_req ? (m_wb || wake) : 1'b0;
        end
    end

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {inak,slak,synced} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(bit i, bit s, bit w, bit b, bit r);
        init_req = i; sleep_req = s; wake = w; stb = b; rx = r;
        @(negedge clk);
    endtask

    task automatic model_check(string req);
        check(req, {inak, slak, synced}, {exp_inak(m_st), exp_slak(m_st), exp_synced(m_st)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        repeat (3) cyc(0, 0, 0, 1, 1);
        check("R1 reset", {inak, slak, synced}, 3'b000);
        rst_n = 1'b1;
        // R1: a run one bit short does not sync; the full run does
        repeat (RUN - 1) cyc(0, 0, 0, 1, 1);
        check("R1 short run", {inak, slak, synced}, 3'b000);
        cyc(0, 0, 0, 1, 1);
        check("R1 full run", {inak, slak, synced}, 3'b001);
        // R2 and R3: init with sleep also high
        cyc(1, 1, 0, 0, 1);
        check("R3 init over sleep", {inak, slak, synced}, 3'b100);
        cyc(1, 0, 0, 1, 1);
        check("R2 init held", {inak, slak, synced}, 3'b100);
        // R4/R5/R6: release init, partial run, dominant, unstrobed dominants
        repeat (5) cyc(0, 0, 0, 1, 1);
        cyc(0, 0, 0, 1, 0);
        check("R5 dominant restart", {inak, slak, synced}, 3'b100);
        for (int k = 0; k < RUN - 1; k++) begin
            cyc(0, 0, 0, 1, 1);
            cyc(0, 0, 0, 0, 0);
        end
        check("R6 unstrobed dominant ignored", {inak, slak, synced}, 3'b100);
        check("R4 inak held before run ends", {inak, slak, synced}, 3'b100);
        cyc(0, 0, 0, 1, 1);
        check("R4 inak clears with sync", {inak, slak, synced}, 3'b001);
        // R7..R9: sleep, wake cancellation, re-arm, exit
        cyc(0, 1, 0, 0, 1);
        check("R7 sleep enter", {inak, slak, synced}, 3'b010);
        cyc(0, 1, 1, 0, 1);
        check("R9 wake cancels", {inak, slak, synced}, 3'b000);
        cyc(0, 1, 0, 0, 1);
        cyc(0, 1, 0, 0, 1);
        check("R9 cancel persists", {inak, slak, synced}, 3'b000);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 1);
        check("R9 re-armed sleep", {inak, slak, synced}, 3'b010);
        cyc(0, 0, 0, 0, 1);
        check("R8 sleep exit", {inak, slak, synced}, 3'b000);
        repeat (RUN - 1) cyc(0, 0, 0, 1, 1);
        check("R8 resync pending", {inak, slak, synced}, 3'b000);
        cyc(0, 0, 0, 1, 1);
        check("R8 resync done", {inak, slak, synced}, 3'b001);
        model_check("R8 model agrees");
        // Random phase against the reference model
        for (int n = 0; n < 6000; n++) begin
            bit i, s, w, b, r;
            i = init_req; s = sleep_req;
            if ($urandom_range(0, 39) == 0) i = !i;
            if ($urandom_range(0, 49) == 0) s = !s;
            w = ($urandom_range(0, 29) == 0);
            b = ($urandom_range(0, 2) == 0);
            r = ($urandom_range(0, 24) != 0);
            cyc(i, s, w, b, r);
            case (m_st)
                1:       model_check("R2 random");
                2:       model_check("R4 random");
                3:       model_check("R7 random");
                0:       model_check("R8 random");
                default: model_check("R6 random");
            endcase
        end
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule